// File: doc/BRIEF.md
# Seconds Real-Time Clock with Alarm Compare

This block keeps wall time as a flat 32-bit binary count of seconds and compares it against a 32-bit alarm value. The clock advances from an external tick input. A parameter sets how many tick pulses make up one second. With the default of one, the tick input is a once-per-second pulse. With a larger value, a sub-second phase counter divides the tick down.

Software reaches everything one byte at a time over a plain register port. The port has an address, write data, a write strobe, a read strobe and registered read data. Time and alarm each occupy four consecutive byte addresses, with the most significant byte at the lowest address. When the alarm matches, a sticky flag is set in the first of three write-one-to-clear interrupt source registers. Other blocks can also set flags in these registers through a set vector. A level interrupt and two wake requests follow from the flags and two control bits.

Reading the top time byte freezes a copy of the whole count. The three lower bytes read from that copy, so a read that starts at the top byte is coherent. Writes to the upper three time bytes go to a staging register. The write of the lowest byte loads all 32 bits at once.

The alarm engine is a two-state machine:
- ALM_OFF: the alarm holds all ones.
- ALM_ARMED: the alarm holds any other value.
- Transition ARM: a byte write that leaves the alarm at any other value moves ALM_OFF to ALM_ARMED.
- Transition DISARM: a byte write that leaves the alarm at all ones moves ALM_ARMED to ALM_OFF.
- Only ALM_ARMED can raise a match.

Top module: `rtc_seconds_core`

## Requirements
- R1: After reset the count is 0, all four alarm bytes read 0xFF, all flags and both control bits are 0, and irq_o, wake_shdn_o and wake_sleep_o are low.
- R2: Read data appears on bus_rdata_o in the cycle after bus_rd_i and holds until the next read. Every address outside 0x10-0x12, 0x29 and 0x70-0x77 reads 0x00.
- R3: The count increases by one after every TICKS_PER_SEC tick pulses. It wraps from 0xFFFFFFFF to 0.
- R4: Reading 0x70 returns count bits 31:24 and freezes the whole count. Reads of 0x71, 0x72 and 0x73 return bits 23:16, 15:8 and 7:0 of that frozen copy, even if the count has moved since.
- R5: Writes to 0x70-0x72 stage bits 31:24, 23:16 and 15:8. A write to 0x73 loads the staged bytes together with the new low byte into the count and clears the sub-second phase. A tick pulse in the cycle of that write is dropped.
- R6: The alarm is written and read at 0x74 (bits 31:24) through 0x77 (bits 7:0).
- R7: When a counted second makes the new count equal the alarm, bit 3 of the register at 0x10 is set at the same clock edge.
- R8: An alarm of 0xFFFFFFFF never sets the alarm flag, even when the count reaches 0xFFFFFFFF.
- R9: Flag registers 0x10, 0x11 and 0x12 hold flag_set_i bits 7:0, 15:8 and 23:16, each pulse setting its flag. Writing a byte clears exactly the flags at its 1 bits. A set and a clear of the same flag in one cycle leave it set.
- R10: irq_o is high exactly when any of the 24 flags is set.
- R11: Register 0x29 stores bit 2 (wake from shutdown) and bit 3 (wake from sleep), and its other bits read 0. wake_shdn_o and wake_sleep_o are each the alarm flag ANDed with the matching control bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base pulse, one cycle wide |
| bus_addr_i | input | 8 | Byte register address |
| bus_wdata_i | input | 8 | Write data |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| flag_set_i | input | 8*NFLAG_REGS | Set pulses from other interrupt sources |
| bus_rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Level interrupt, OR of all flags |
| wake_shdn_o | output | 1 | Wake-from-shutdown request |
| wake_sleep_o | output | 1 | Wake-from-sleep request |

## Verification
The bench builds the block with TICKS_PER_SEC set to 4, a 32-bit count and three flag registers. A divide of four makes the sub-second phase observable: a load in mid-second, or a tick dropped on the load cycle, moves the next increment by a countable number of pulses. The 8-bit address and flag widths keep exhaustive sweeps short: all 256 addresses at reset, all 256 control values with the alarm flag set, and all 24 flags through set, partial clear and full clear. The top of the count range is reached by loading values near it, which exercises the wrap, a frozen copy spanning a carry, and an all-ones alarm sitting under a count of all ones.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;
    localparam int ADDR_W = 8;
    localparam int BYTE_W = 8;

    // Map: software decodes these offsets, so they are fixed.
    localparam logic [ADDR_W-1:0] FLAG_BASE  = 8'h10;
    localparam logic [ADDR_W-1:0] CTRL_ADDR  = 8'h29;
    localparam logic [ADDR_W-1:0] TIME_BASE  = 8'h70;
    localparam logic [ADDR_W-1:0] ALARM_BASE = 8'h74;

    localparam int ALARM_FLAG_BIT = 3;
    localparam int CTRL_SHDN_BIT  = 2;
    localparam int CTRL_SLEEP_BIT = 3;

    typedef enum logic {
        ALM_OFF   = 1'b0,
        ALM_ARMED = 1'b1
    } alm_state_e;
endpackage

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter
    import rtc_sec_pkg::*;
#(
    parameter int CNT_W         = 32,
    parameter int TICKS_PER_SEC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              sec_pulse_o
);
    localparam int NBYTES = CNT_W / BYTE_W;
    localparam logic [ADDR_W-1:0] LOAD_ADDR = ADDR_W'(int'(TIME_BASE) + NBYTES - 1);

    logic [CNT_W-1:BYTE_W] stage_q;
    logic [CNT_W-1:0]      count_q;
    logic                  load_w;
    logic                  sec_w;

    assign load_w = wr_en_i && (addr_i == LOAD_ADDR);

    // Upper bytes wait here until the lowest byte commits them.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (wr_en_i) begin
            for (int i = 0; i < NBYTES - 1; i++) begin
                if (addr_i == ADDR_W'(int'(TIME_BASE) + i))
                    stage_q[CNT_W-1-BYTE_W*i -: BYTE_W] <= wdata_i;
            end
        end
    end

    generate
        if (TICKS_PER_SEC > 1) begin : g_presc
            localparam int PH_W = $clog2(TICKS_PER_SEC);
            localparam logic [PH_W-1:0] PH_LAST = PH_W'(TICKS_PER_SEC - 1);
            logic [PH_W-1:0] phase_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    phase_q <= '0;
                end else if (load_w) begin
                    phase_q <= '0;
                end else if (tick_i) begin
                    phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
                end
            end

            assign sec_w = tick_i && !load_w && (phase_q == PH_LAST);
        end else begin : g_direct
            assign sec_w = tick_i && !load_w;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load_w) begin
            count_q <= {stage_q, wdata_i};
        end else if (sec_w) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count_o     = count_q;
    assign sec_pulse_o = sec_w;
endmodule

// File: rtl/rtc_sec_alarm.sv
module rtc_sec_alarm
    import rtc_sec_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              sec_pulse_i,
    output logic [CNT_W-1:0]  alarm_o,
    output logic              hit_o
);
    localparam int NBYTES = CNT_W / BYTE_W;

    logic [CNT_W-1:0] alarm_q;
    logic [CNT_W-1:0] alarm_d;
    logic [CNT_W-1:0] next_cnt;
    alm_state_e       state_q;
    alm_state_e       state_d;

    // Next alarm value and state: ARM when a write leaves a usable value,
    // DISARM when it leaves all ones.
    always_comb begin
        alarm_d = alarm_q;
        if (wr_en_i) begin
            for (int i = 0; i < NBYTES; i++) begin
                if (addr_i == ADDR_W'(int'(ALARM_BASE) + i))
                    alarm_d[CNT_W-1-BYTE_W*i -: BYTE_W] = wdata_i;
            end
        end
        state_d = (alarm_d == {CNT_W{1'b1}}) ? ALM_OFF : ALM_ARMED;
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alarm_q <= {CNT_W{1'b1}};
            state_q <= ALM_OFF;
        end else begin
            alarm_q <= alarm_d;
            state_q <= state_d;
        end
    end

    assign next_cnt = count_i + 1'b1;

    // Outputs.
    always_comb begin
        hit_o = 1'b0;
        unique case (state_q)
            ALM_OFF:   hit_o = 1'b0;
            ALM_ARMED: hit_o = sec_pulse_i && (next_cnt == alarm_q);
        endcase
    end

    assign alarm_o = alarm_q;
endmodule

// File: rtl/rtc_sec_regs.sv
module rtc_sec_regs
    import rtc_sec_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int NFLAG_REGS = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en_i,
    input  logic                         rd_en_i,
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic [BYTE_W-1:0]            wdata_i,
    input  logic [CNT_W-1:0]             count_i,
    input  logic [CNT_W-1:0]             alarm_i,
    input  logic                         hit_i,
    input  logic [NFLAG_REGS*BYTE_W-1:0] flag_set_i,
    output logic [BYTE_W-1:0]            rdata_o,
    output logic [NFLAG_REGS*BYTE_W-1:0] flags_o,
    output logic                         ctrl_shdn_o,
    output logic                         ctrl_sleep_o
);
    localparam int NBYTES = CNT_W / BYTE_W;
    localparam int FLAG_W = NFLAG_REGS * BYTE_W;

    logic [FLAG_W-1:0] flags_q, flags_d, flag_clr, flag_set;
    logic [CNT_W-1:0]  snap_q;
    logic [BYTE_W-1:0] rdata_q, rd_mux;
    logic              shdn_q, sleep_q;

    // Flags: set beats clear in the same cycle.
    always_comb begin
        flag_clr = '0;
        if (wr_en_i) begin
            for (int j = 0; j < NFLAG_REGS; j++) begin
                if (addr_i == ADDR_W'(int'(FLAG_BASE) + j))
                    flag_clr[BYTE_W*j +: BYTE_W] = wdata_i;
            end
        end
        flag_set = flag_set_i;
        flag_set[ALARM_FLAG_BIT] = flag_set_i[ALARM_FLAG_BIT] | hit_i;
        flags_d = (flags_q & ~flag_clr) | flag_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            shdn_q  <= 1'b0;
            sleep_q <= 1'b0;
        end else begin
            flags_q <= flags_d;
            if (wr_en_i && addr_i == CTRL_ADDR) begin
                shdn_q  <= wdata_i[CTRL_SHDN_BIT];
                sleep_q <= wdata_i[CTRL_SLEEP_BIT];
            end
        end
    end

    // Read mux: the top time byte comes live, the rest from the copy.
    always_comb begin
        rd_mux = '0;
        if (addr_i == TIME_BASE)
            rd_mux = count_i[CNT_W-1 -: BYTE_W];
        for (int i = 1; i < NBYTES; i++) begin
            if (addr_i == ADDR_W'(int'(TIME_BASE) + i))
                rd_mux = snap_q[CNT_W-1-BYTE_W*i -: BYTE_W];
        end
        for (int i = 0; i < NBYTES; i++) begin
            if (addr_i == ADDR_W'(int'(ALARM_BASE) + i))
                rd_mux = alarm_i[CNT_W-1-BYTE_W*i -: BYTE_W];
        end
        for (int j = 0; j < NFLAG_REGS; j++) begin
            if (addr_i == ADDR_W'(int'(FLAG_BASE) + j))
                rd_mux = flags_q[BYTE_W*j +: BYTE_W];
        end
        if (addr_i == CTRL_ADDR) begin
            rd_mux[CTRL_SHDN_BIT]  = shdn_q;
            rd_mux[CTRL_SLEEP_BIT] = sleep_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            snap_q  <= '0;
        end else if (rd_en_i) begin
            rdata_q <= rd_mux;
            if (addr_i == TIME_BASE)
                snap_q <= count_i;
        end
    end

    assign rdata_o      = rdata_q;
    assign flags_o      = flags_q;
    assign ctrl_shdn_o  = shdn_q;
    assign ctrl_sleep_o = sleep_q;
endmodule

// File: rtl/rtc_seconds_core.sv
module rtc_seconds_core
    import rtc_sec_pkg::*;
#(
    parameter int CNT_W         = 32,
    parameter int TICKS_PER_SEC = 1,
    parameter int NFLAG_REGS    = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         tick_i,
    input  logic [7:0]                   bus_addr_i,
    input  logic [7:0]                   bus_wdata_i,
    input  logic                         bus_wr_i,
    input  logic                         bus_rd_i,
    input  logic [NFLAG_REGS*8-1:0]      flag_set_i,
    output logic [7:0]                   bus_rdata_o,
    output logic                         irq_o,
    output logic                         wake_shdn_o,
    output logic                         wake_sleep_o
);
    logic [CNT_W-1:0]             count_w;
    logic [CNT_W-1:0]             alarm_w;
    logic                         sec_pulse_w;
    logic                         hit_w;
    logic [NFLAG_REGS*8-1:0]      flags_w;
    logic                         ctrl_shdn_w;
    logic                         ctrl_sleep_w;

    rtc_sec_counter #(
        .CNT_W         (CNT_W),
        .TICKS_PER_SEC (TICKS_PER_SEC)
    ) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .wr_en_i     (bus_wr_i),
        .addr_i      (bus_addr_i),
        .wdata_i     (bus_wdata_i),
        .count_o     (count_w),
        .sec_pulse_o (sec_pulse_w)
    );

    rtc_sec_alarm #(
        .CNT_W (CNT_W)
    ) u_alarm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (bus_wr_i),
        .addr_i      (bus_addr_i),
        .wdata_i     (bus_wdata_i),
        .count_i     (count_w),
        .sec_pulse_i (sec_pulse_w),
        .alarm_o     (alarm_w),
        .hit_o       (hit_w)
    );

    rtc_sec_regs #(
        .CNT_W      (CNT_W),
        .NFLAG_REGS (NFLAG_REGS)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (bus_wr_i),
        .rd_en_i      (bus_rd_i),
        .addr_i       (bus_addr_i),
        .wdata_i      (bus_wdata_i),
        .count_i      (count_w),
        .alarm_i      (alarm_w),
        .hit_i        (hit_w),
        .flag_set_i   (flag_set_i),
        .rdata_o      (bus_rdata_o),
        .flags_o      (flags_w),
        .ctrl_shdn_o  (ctrl_shdn_w),
        .ctrl_sleep_o (ctrl_sleep_w)
    );

    assign irq_o        = |flags_w;
    assign wake_shdn_o  = flags_w[ALARM_FLAG_BIT] & ctrl_shdn_w;
    assign wake_sleep_o = flags_w[ALARM_FLAG_BIT] & ctrl_sleep_w;
endmodule

// File: rtl/rtc_seconds_core_chk.sv
module rtc_seconds_core_chk
    import rtc_sec_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int NFLAG_REGS = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [7:0]              bus_addr,
    input logic [7:0]              bus_wdata,
    input logic                    bus_wr,
    input logic [NFLAG_REGS*8-1:0] flag_set,
    input logic                    irq,
    input logic                    wake_shdn,
    input logic                    wake_sleep,
    input logic [CNT_W-1:0]        count,
    input logic [CNT_W-1:0]        alarm,
    input logic [NFLAG_REGS*8-1:0] flags,
    input logic                    hit,
    input logic                    sec_pulse
);
    localparam logic [7:0] LOAD_ADDR = 8'(int'(TIME_BASE) + CNT_W / BYTE_W - 1);

    a_r3_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |=> (count == CNT_W'($past(count) + 1'b1)));

    a_r5_load_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == LOAD_ADDR) |=> (count[7:0] == $past(bus_wdata)));

    a_r8_all_ones_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm == {CNT_W{1'b1}}) |-> !hit);

    a_r7_hit_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flags[ALARM_FLAG_BIT]);

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[ALARM_FLAG_BIT] && !(bus_wr && bus_addr == FLAG_BASE && bus_wdata[ALARM_FLAG_BIT]))
        |=> flags[ALARM_FLAG_BIT]);

    a_r9_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == FLAG_BASE && bus_wdata[ALARM_FLAG_BIT] && !hit && !flag_set[ALARM_FLAG_BIT])
        |=> !flags[ALARM_FLAG_BIT]);

    a_r10_irq_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> irq);

    a_r11_wake_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_shdn || wake_sleep) |-> flags[ALARM_FLAG_BIT]);
endmodule

bind rtc_seconds_core rtc_seconds_core_chk #(
    .CNT_W      (CNT_W),
    .NFLAG_REGS (NFLAG_REGS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr_i),
    .bus_wdata  (bus_wdata_i),
    .bus_wr     (bus_wr_i),
    .flag_set   (flag_set_i),
    .irq        (irq_o),
    .wake_shdn  (wake_shdn_o),
    .wake_sleep (wake_sleep_o),
    .count      (count_w),
    .alarm      (alarm_w),
    .flags      (flags_w),
    .hit        (hit_w),
    .sec_pulse  (sec_pulse_w)
);

// File: tb/rtc_seconds_core_test.sv
module rtc_seconds_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [7:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [23:0] fset = '0;
    logic [7:0]  rdata;
    logic        irq, wake_shdn, wake_sleep;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    rtc_seconds_core #(
        .CNT_W         (32),
        .TICKS_PER_SEC (4),
        .NFLAG_REGS    (3)
    ) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick),
        .bus_addr_i   (addr),
        .bus_wdata_i  (wdata),
        .bus_wr_i     (wr),
        .bus_rd_i     (rd),
        .flag_set_i   (fset),
        .bus_rdata_o  (rdata),
        .irq_o        (irq),
        .wake_shdn_o  (wake_shdn),
        .wake_sleep_o (wake_sleep)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic rd_time(output logic [31:0] t);
        logic [7:0] b;
        t = '0;
        for (int i = 0; i < 4; i++) begin
            rd_reg(8'(8'h70 + i), b);
            t = {t[23:0], b};
        end
    endtask

    task automatic rd_alarm(output logic [31:0] t);
        logic [7:0] b;
        t = '0;
        for (int i = 0; i < 4; i++) begin
            rd_reg(8'(8'h74 + i), b);
            t = {t[23:0], b};
        end
    endtask

    task automatic set_time(input logic [31:0] t);
        for (int i = 0; i < 4; i++)
            wr_reg(8'(8'h70 + i), t[31-8*i -: 8]);
    endtask

    task automatic set_alarm(input logic [31:0] t);
        for (int i = 0; i < 4; i++)
            wr_reg(8'(8'h74 + i), t[31-8*i -: 8]);
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0]  d;
        logic [31:0] t;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R2: whole address space after reset
        check("R1 irq at reset", 32'(irq), 32'h0);
        check("R1 wake_shdn at reset", 32'(wake_shdn), 32'h0);
        check("R1 wake_sleep at reset", 32'(wake_sleep), 32'h0);
        for (int a = 0; a < 256; a++) begin
            logic [7:0] e;
            e = (a >= 8'h74 && a <= 8'h77) ? 8'hFF : 8'h00;
            rd_reg(8'(a), d);
            check((a >= 8'h74 && a <= 8'h77) ? "R1 alarm reset byte" : "R2 reset/unmapped read",
                  32'(d), 32'(e));
        end

        // R2: read data holds without a read strobe
        rd_reg(8'h74, d);
        wr_reg(8'h29, 8'h0C);
        @(negedge clk);
        check("R2 rdata holds", 32'(rdata), 32'hFF);
        wr_reg(8'h29, 8'h00);

        // R5 / R4: staged load and coherent read
        set_time(32'h12345678);
        rd_time(t);
        check("R5 load value", t, 32'h12345678);

        // R3: one second per four ticks
        ticks(3);
        rd_time(t);
        check("R3 no step before 4 ticks", t, 32'h12345678);
        ticks(1);
        rd_time(t);
        check("R3 step on 4th tick", t, 32'h12345679);

        // R5: load clears phase and drops a simultaneous tick
        ticks(2);
        set_time(32'h0A0B0C00);
        wr_reg(8'h70, 8'h0A);
        @(negedge clk);
        addr = 8'h73; wdata = 8'h0D; wr = 1'b1; tick = 1'b1;
        @(negedge clk);
        wr = 1'b0; tick = 1'b0;
        rd_time(t);
        check("R5 load with tick", t, 32'h0A0B0C0D);
        ticks(3);
        rd_time(t);
        check("R5 phase cleared by load", t, 32'h0A0B0C0D);
        ticks(1);
        rd_time(t);
        check("R5 first second after load", t, 32'h0A0B0C0E);

        // R4: frozen copy across a carry
        set_time(32'h01FFFFFF);
        rd_reg(8'h70, d);
        check("R4 top byte", 32'(d), 32'h01);
        ticks(4);
        for (int i = 1; i < 4; i++) begin
            rd_reg(8'(8'h70 + i), d);
            check("R4 frozen lower byte", 32'(d), 32'hFF);
        end
        rd_time(t);
        check("R4 fresh read after carry", t, 32'h02000000);

        // R8 / R3: all-ones alarm under all-ones count, then wrap
        set_time(32'hFFFFFFFE);
        ticks(4);
        rd_time(t);
        check("R3 reach top", t, 32'hFFFFFFFF);
        rd_reg(8'h10, d);
        check("R8 all-ones alarm silent", 32'(d), 32'h00);
        check("R8 irq low", 32'(irq), 32'h0);
        ticks(4);
        rd_time(t);
        check("R3 wrap to zero", t, 32'h00000000);

        // R6: alarm readback
        set_alarm(32'h11223344);
        rd_alarm(t);
        check("R6 alarm readback", t, 32'h11223344);

        // R7 / R10: alarm match
        set_time(32'h00000100);
        set_alarm(32'h00000102);
        ticks(4);
        rd_reg(8'h10, d);
        check("R7 no flag before match", 32'(d), 32'h00);
        ticks(4);
        rd_reg(8'h10, d);
        check("R7 flag on match", 32'(d), 32'h08);
        check("R10 irq on alarm", 32'(irq), 32'h1);
        check("R11 wake_shdn off with ctrl 0", 32'(wake_shdn), 32'h0);
        check("R11 wake_sleep off with ctrl 0", 32'(wake_sleep), 32'h0);

        // R11: every control value with the alarm flag set
        for (int v = 0; v < 256; v++) begin
            wr_reg(8'(v), 8'h00);
            wr_reg(8'h29, 8'(v));
            rd_reg(8'h29, d);
            check("R11 ctrl readback", 32'(d), 32'(v & 8'h0C));
            check("R11 wake_shdn", 32'(wake_shdn), 32'((v >> 2) & 1));
            check("R11 wake_sleep", 32'(wake_sleep), 32'((v >> 3) & 1));
        end
        wr_reg(8'h29, 8'h00);

        // R9: clear the alarm flag
        wr_reg(8'h10, 8'h08);
        rd_reg(8'h10, d);
        check("R9 alarm flag cleared", 32'(d), 32'h00);
        check("R10 irq low after clear", 32'(irq), 32'h0);

        // R9 / R10: every flag bit
        for (int b = 0; b < 24; b++) begin
            logic [7:0] ra;
            logic [7:0] bv;
            ra = 8'(16 + b / 8);
            bv = 8'(1 << (b % 8));
            @(negedge clk); fset = 24'(1) << b;
            @(negedge clk); fset = '0;
            rd_reg(ra, d);
            check("R9 flag set", 32'(d), 32'(bv));
            check("R10 irq with one flag", 32'(irq), 32'h1);
            wr_reg(ra, ~bv);
            rd_reg(ra, d);
            check("R9 other bits leave flag", 32'(d), 32'(bv));
            wr_reg(ra, bv);
            rd_reg(ra, d);
            check("R9 flag cleared", 32'(d), 32'h00);
            check("R10 irq low", 32'(irq), 32'h0);
        end

        // R9: set beats clear in the same cycle
        @(negedge clk);
        fset = 24'h000100; addr = 8'h11; wdata = 8'h01; wr = 1'b1;
        @(negedge clk);
        fset = '0; wr = 1'b0;
        rd_reg(8'h11, d);
        check("R9 set wins over clear", 32'(d), 32'h01);
        wr_reg(8'h11, 8'h01);
        rd_reg(8'h11, d);
        check("R9 cleared afterwards", 32'(d), 32'h00);

        summary();
        $finish;
    end
endmodule